// File: doc/BRIEF.md
# GPIO Interrupt Detector with Pending and Enable Words

This block watches a bank of general-purpose input pins and turns selected transitions or levels into latched interrupt events. Every pin arrives asynchronously and passes through a multi-stage synchronizer. A further register keeps the previous synchronized sample, and edges are found by comparing the two. Each pin has two configuration inputs: a trigger-select bit (0 = edge, 1 = level) and an invert bit. Together they give four trigger kinds. Select 0 with invert 0 is a rising edge. Select 0 with invert 1 is a falling edge. Select 1 with invert 0 is a low level. Select 1 with invert 1 is a high level.

Detected events are held in pending bits, packed 32 pins to a word. Software reads these words and clears chosen bits by writing ones. A second set of 32-bit words holds per-pin enables. The single parent interrupt output is high whenever any pin has both its pending bit and its enable bit set. The configuration bits come from a register decoder outside this block.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: In rising-edge mode (select 0, invert 0), a 0-to-1 change on a pin sets its pending bit. The bit is readable on the third rising clock edge after the input change. A 1-to-0 change sets nothing.
- R2: In falling-edge mode (select 0, invert 1), a 1-to-0 change sets the pending bit with the same three-edge latency. A 0-to-1 change sets nothing.
- R3: In low-level mode (select 1, invert 0), the pending bit sets while the synchronized input is 0. A clear has no visible effect while the input stays low. Once the input has been high long enough to be synchronized, a clear removes the bit.
- R4: In high-level mode (select 1, invert 1), the pending bit sets while the synchronized input is 1. It behaves the same way as R3 with the polarity reversed.
- R5: A write to a pending word clears each bit written as 1 and leaves each bit written as 0 unchanged. Writing all ones clears the whole group.
- R6: If a new event for a pin arrives in the same cycle as a clear of that pin's bit, the bit stays pending.
- R7: Pending bits latch whatever the enable bits hold. The enables affect only the parent interrupt.
- R8: The interrupt output is high exactly when some pin has both its pending bit and its enable bit set. This holds across all groups. An enable write replaces the whole enable word for its group.
- R9: The pending word of group g is at byte address 0x80+4g, and the enable word of group g is at 0x90+4g. Bit i of a word belongs to pin 32g+i. Bits with no pin read 0, and any other address reads 0.
- R10: After reset, every pending bit and every enable bit is 0, and the interrupt output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| pin_in | input | 94 | Asynchronous pin inputs |
| trig_level | input | 94 | Per-pin trigger select: 0 = edge, 1 = level |
| trig_inv | input | 94 | Per-pin trigger invert |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| irq_o | output | 1 | Parent interrupt, OR of enabled pending bits |

## Verification
The hardest case to reach from the ports is a clear write that lands on the exact edge where a fresh event is captured. The input change must be timed so that the event appears two edges later, in the same cycle that the write strobe is sampled. The bench first leaves a rising-edge pin pending. It then raises the pin again at a falling clock edge and issues the clear write after exactly two rising edges, so the event and the clear meet on the same edge. The bench also sweeps all four trigger kinds over every pin. For each pin it checks the latency, the opposite transition, the clear behaviour and the enable masking.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

  localparam int WORD_W = 32;
  localparam logic [7:0] ADDR_STAT_BASE = 8'h80;
  localparam logic [7:0] ADDR_EN_BASE   = 8'h90;

  // Event for one pin from its trigger config and its current/previous samples
  function automatic logic trig_event(input logic lvl, input logic inv,
                                      input logic cur, input logic prev);
    logic hit;
    if (lvl) hit = cur ~^ inv;                  // inv=0: low level, inv=1: high level
    else if (inv) hit = ~cur & prev;            // falling edge
    else hit = cur & ~prev;                     // rising edge
    return hit;
  endfunction

endpackage

// File: rtl/gpio_irq_sync.sv
module gpio_irq_sync #(
  parameter int W      = 94,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o,
  output logic [W-1:0] prev_o
);

  logic [STAGES-1:0][W-1:0] stage_q;
  logic [STAGES-1:0][W-1:0] stage_d;
  logic [W-1:0]             prev_q;

  always_comb begin
    stage_d[0] = async_i;
    for (int s = 1; s < STAGES; s++) stage_d[s] = stage_q[s-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= '0;
      prev_q  <= '0;
    end else begin
      stage_q <= stage_d;
      prev_q  <= stage_q[STAGES-1];
    end
  end

  assign sync_o = stage_q[STAGES-1];
  assign prev_o = prev_q;

endmodule

// File: rtl/gpio_irq_group.sv
module gpio_irq_group #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] sync_i,
  input  logic [W-1:0] prev_i,
  input  logic [W-1:0] lvl_i,
  input  logic [W-1:0] inv_i,
  input  logic [W-1:0] stat_clr_i,
  input  logic         en_wr_i,
  input  logic [W-1:0] en_data_i,
  output logic [W-1:0] stat_o,
  output logic [W-1:0] en_o,
  output logic         pend_o
);

  logic [W-1:0] evt;
  logic [W-1:0] stat_q, stat_d;
  logic [W-1:0] en_q, en_d;

  for (genvar i = 0; i < W; i++) begin : g_det
    assign evt[i] = gpio_irq_pkg::trig_event(lvl_i[i], inv_i[i], sync_i[i], prev_i[i]);
  end

  always_comb begin
    stat_d = (stat_q & ~stat_clr_i) | evt;   // a new event overrides a clear
    en_d   = en_q;
    if (en_wr_i) en_d = en_data_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0;
      en_q   <= '0;
    end else begin
      stat_q <= stat_d;
      en_q   <= en_d;
    end
  end

  assign stat_o = stat_q;
  assign en_o   = en_q;
  assign pend_o = |(stat_q & en_q);

  AST_EVENT_LATCHES: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt) |=> ((stat_q & $past(evt)) == $past(evt))); // R6

  AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (|(stat_clr_i & ~evt)) |=> ((stat_q & $past(stat_clr_i & ~evt)) == '0)); // R5

  AST_NO_SPURIOUS_SET: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((stat_q & ~$past(stat_q) & ~$past(evt)) == '0)); // R1

  AST_EN_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !en_wr_i |=> $stable(en_q)); // R8

endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl #(
  parameter int NUM_PINS    = 94,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] pin_in,
  input  logic [NUM_PINS-1:0] trig_level,
  input  logic [NUM_PINS-1:0] trig_inv,
  input  logic                reg_wr,
  input  logic [7:0]          reg_addr,
  input  logic [31:0]         reg_wdata,
  output logic [31:0]         reg_rdata,
  output logic                irq_o
);

  localparam int WORD_W     = gpio_irq_pkg::WORD_W;
  localparam int NUM_GROUPS = (NUM_PINS + WORD_W - 1) / WORD_W;

  logic [NUM_PINS-1:0]   sync_v, prev_v;
  logic [WORD_W-1:0]     stat_word [NUM_GROUPS];
  logic [WORD_W-1:0]     en_word   [NUM_GROUPS];
  logic [NUM_GROUPS-1:0] pend;
  logic [NUM_GROUPS-1:0] en_nz, stat_nz;

  gpio_irq_sync #(.W(NUM_PINS), .STAGES(SYNC_STAGES)) sync_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i (pin_in),
    .sync_o  (sync_v),
    .prev_o  (prev_v)
  );

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
    localparam int LO = g * WORD_W;
    localparam int GW = (NUM_PINS - LO) < WORD_W ? (NUM_PINS - LO) : WORD_W;

    logic          stat_hit, en_hit;
    logic [GW-1:0] clr, stat_g, en_g;

    assign stat_hit = reg_wr && (reg_addr == 8'(gpio_irq_pkg::ADDR_STAT_BASE + 4*g));
    assign en_hit   = reg_wr && (reg_addr == 8'(gpio_irq_pkg::ADDR_EN_BASE + 4*g));
    assign clr      = stat_hit ? reg_wdata[GW-1:0] : '0;

    gpio_irq_group #(.W(GW)) grp_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .sync_i     (sync_v[LO +: GW]),
      .prev_i     (prev_v[LO +: GW]),
      .lvl_i      (trig_level[LO +: GW]),
      .inv_i      (trig_inv[LO +: GW]),
      .stat_clr_i (clr),
      .en_wr_i    (en_hit),
      .en_data_i  (reg_wdata[GW-1:0]),
      .stat_o     (stat_g),
      .en_o       (en_g),
      .pend_o     (pend[g])
    );

    assign stat_word[g] = WORD_W'(stat_g);
    assign en_word[g]   = WORD_W'(en_g);
    assign en_nz[g]     = |en_g;
    assign stat_nz[g]   = |stat_g;
  end

  always_comb begin
    reg_rdata = '0;
    for (int g = 0; g < NUM_GROUPS; g++) begin
      if (reg_addr == 8'(gpio_irq_pkg::ADDR_STAT_BASE + 4*g)) reg_rdata = stat_word[g];
      if (reg_addr == 8'(gpio_irq_pkg::ADDR_EN_BASE + 4*g))   reg_rdata = en_word[g];
    end
  end

  assign irq_o = |pend;

  AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (|en_nz)); // R8

  AST_IRQ_NEEDS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (|stat_nz)); // R7

endmodule

// File: tb/gpio_irq_ctrl_tb_top.sv
module gpio_irq_ctrl_tb_top;

  localparam int NP = 94;

  logic          clk;
  logic          rst_n;
  logic [NP-1:0] pin_in, trig_level, trig_inv;
  logic          reg_wr;
  logic [7:0]    reg_addr;
  logic [31:0]   reg_wdata, reg_rdata;
  logic          irq_o;

  int n_chk  = 0;
  int n_fail = 0;

  gpio_irq_ctrl #(.NUM_PINS(NP), .SYNC_STAGES(2)) dut_i (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .trig_level(trig_level),
    .trig_inv(trig_inv), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_o(irq_o)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk);
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic clear_all();
    for (int g = 0; g < 3; g++) wr(8'(8'h80 + 4*g), 32'hFFFF_FFFF);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] d;
    rst_n = 1'b0; pin_in = '0; trig_level = '0; trig_inv = '0;
    reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
    cyc(3);
    rst_n = 1'b1;
    cyc(1);

    // R10: reset state
    for (int g = 0; g < 3; g++) begin
      rd(8'(8'h80 + 4*g), d); chk("R10 pending reset", d, 0);
      rd(8'(8'h90 + 4*g), d); chk("R10 enable reset", d, 0);
    end
    chk("R10 irq reset", 32'(irq_o), 0);

    // Sweep all four trigger kinds over every pin
    for (int m = 0; m < 4; m++) begin
      logic lvl, inv, act, idle;
      string tag;
      lvl = m[1]; inv = m[0];
      act = ~(lvl ^ inv); idle = ~act;
      case (m)
        0: tag = "R1";
        1: tag = "R2";
        2: tag = "R3";
        default: tag = "R4";
      endcase
      trig_level = {NP{lvl}}; trig_inv = {NP{inv}}; pin_in = {NP{idle}};
      cyc(5);
      clear_all();
      for (int p = 0; p < NP; p++) begin
        logic [7:0] sa, ea;
        logic [31:0] bm;
        sa = 8'(8'h80 + 4*(p/32)); ea = 8'(8'h90 + 4*(p/32));
        bm = 32'h1 << (p % 32);
        rd(sa, d); chk({tag, " idle"}, d, 0);
        pin_in[p] = act;
        cyc(2);
        rd(sa, d); chk({tag, " latency before third edge"}, d, 0);
        cyc(1);
        rd(sa, d); chk({tag, " set on third edge"}, d, bm);
        chk("R7 pending with enable off, irq low", 32'(irq_o), 0);
        wr(ea, ~bm); chk("R8 other enables only", 32'(irq_o), 0);
        wr(ea, bm);  chk("R8 enabled pending drives irq", 32'(irq_o), 1);
        wr(ea, 0);
        wr(sa, ~bm); rd(sa, d); chk("R5 zero bit keeps pending", d, bm);
        wr(sa, bm);
        if (!lvl) begin
          rd(sa, d); chk("R5 one bit clears", d, 0);
          pin_in[p] = idle;
          cyc(4);
          rd(sa, d); chk({tag, " opposite edge ignored"}, d, 0);
        end else begin
          rd(sa, d); chk({tag, " level still active re-asserts"}, d, bm);
          pin_in[p] = idle;
          cyc(3);
          wr(sa, bm); rd(sa, d); chk("R5 clear after level removed", d, 0);
          cyc(2);
          rd(sa, d); chk({tag, " inactive level sets nothing"}, d, 0);
        end
      end
    end

    // R6: clear and new event on the same edge
    trig_level = '0; trig_inv = '0; pin_in = '0;
    cyc(5);
    clear_all();
    pin_in[40] = 1'b1; cyc(4);
    pin_in[40] = 1'b0; cyc(4);
    rd(8'h84, d); chk("R6 setup pending", d, 32'h100);
    pin_in[40] = 1'b1;
    cyc(2);
    wr(8'h84, 32'h100);
    rd(8'h84, d); chk("R6 set wins over clear", d, 32'h100);
    wr(8'h84, 32'h100);
    rd(8'h84, d); chk("R5 clear without event", d, 0);

    // R5: all-ones write clears a whole group; R8 across groups
    pin_in = '0; cyc(4);
    pin_in[93:64] = '1; pin_in[3] = 1'b1; cyc(4);
    rd(8'h88, d); chk("R1 many pins pending", d, 32'h3FFF_FFFF);
    wr(8'h90, 32'h8);
    chk("R8 irq from group 0", 32'(irq_o), 1);
    wr(8'h80, 32'hFFFF_FFFF);
    chk("R8 irq drops when enabled pin cleared", 32'(irq_o), 0);
    wr(8'h98, 32'h2000_0000);
    chk("R8 irq from group 2", 32'(irq_o), 1);
    wr(8'h88, 32'hFFFF_FFFF);
    rd(8'h88, d); chk("R5 all ones clears group", d, 0);
    chk("R8 irq low after group clear", 32'(irq_o), 0);

    // R9: address map and unused bits
    wr(8'h98, 32'hFFFF_FFFF);
    rd(8'h98, d); chk("R9 unused enable bits read 0", d, 32'h3FFF_FFFF);
    rd(8'h8C, d); chk("R9 unmapped address reads 0", d, 0);
    rd(8'hA0, d); chk("R9 unmapped address reads 0", d, 0);
    wr(8'h98, 0);
    rd(8'h90, d); chk("R9 enable word group 0", d, 32'h8);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule